// File: doc/BRIEF.md
# Physical Register Readiness Scoreboard with Operand Wakeup

The block keeps one ready bit per physical register and a small table of waiting instruction-queue slots. When dispatch writes an instruction into a slot, it presents up to two source register numbers, each with a flag from rename saying the value is already known to be available, plus one destination register number. The block reports in the same cycle which sources are ready. Each source that is not ready is recorded as waiting on its register. The destination's ready bit is cleared for the next cycle.

A completion broadcast names one destination register. It sets that register's ready bit and releases every slot source waiting on it. A slot raises its entry-ready output once no source is waiting. A broadcast in the same cycle as an insertion that reads the same register is bypassed, so the wakeup is not lost. Register numbers at or above the physical register count are never tracked. A source with such a number counts as ready, and a destination or broadcast with such a number changes nothing. A flush mask removes slots together with their waiting links. Choosing which ready slot to issue is left to the surrounding logic.

Top module: `wakeup_scoreboard`

## Requirements
- R1: While reset is high and in the first cycle after it, every bit of `reg_ready` and of `entry_ready` is 0.
- R2: During an insertion, `ins_src_ready[s]` is 1 in the same cycle if the rename flag `ins_src_rdy[s]` is set or the source register's scoreboard bit is already set. A slot whose two sources are both ready shows `entry_ready` high in the cycle after the insertion.
- R3: A source reported not ready keeps its slot's `entry_ready` low until a completion of that register is broadcast. `entry_ready` rises in the cycle after that broadcast.
- R4: An insertion whose destination number is below `NUM_PREGS` clears that register's `reg_ready` bit in the cycle after the insertion. This holds even if a completion of the same register is broadcast in the same cycle.
- R5: A completion broadcast of a tracked register sets its `reg_ready` bit and releases the waiting sources of all slots on that register in one step. All those slots show `entry_ready` high in the next cycle.
- R6: If a completion of register X is broadcast in the same cycle as an insertion with a not-ready source X, that source is reported ready and never waits.
- R7: A register number at or above `NUM_PREGS` is ignored. As a source it is reported ready. As a destination or broadcast it changes no `reg_ready` bit and releases no slot.
- R8: `prod_err` is 1 during an insertion whose tracked destination register is still awaited by a waiting source of some other valid slot. The exception is when a completion of that same register is broadcast in the same cycle. Otherwise `prod_err` is 0.
- R9: A slot whose `flush_mask` bit is set (and that is not written in the same cycle) shows `entry_ready` low in the next cycle. A later broadcast does not raise it again. An insertion into a slot in the same cycle as its flush takes effect.
- R10: `reg_ready` changes only in the cycle after an insertion or a completion broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert an instruction this cycle |
| ins_slot | input | IDX_W | Queue slot being written |
| ins_src_reg | input | 2*REG_W | Source register numbers, source 0 in the low field |
| ins_src_rdy | input | 2 | Rename says the source is already available |
| ins_dst_reg | input | REG_W | Destination register number (use a number >= NUM_PREGS for none) |
| cmp_valid | input | 1 | Completion broadcast this cycle |
| cmp_reg | input | REG_W | Register being completed |
| flush_mask | input | NUM_ENTRIES | Slots to remove |
| ins_src_ready | output | 2 | Per-source ready report for the current insertion |
| prod_err | output | 1 | Destination still has waiting dependents |
| entry_ready | output | NUM_ENTRIES | Slot holds a valid instruction with all sources ready |
| reg_ready | output | NUM_PREGS | Scoreboard bits |

## Verification
On every cycle, the assertions check that a broadcast sets its bit and an insertion clears its destination bit in the following cycle. They also check that the scoreboard holds still when neither happens, that out-of-range and rename-flagged sources are reported ready, and that flushed slots drop their ready output. The bench scenarios cover the rest, because those properties need history across several cycles. These are the multi-slot wakeup from one broadcast, the same-cycle bypass, the duplicate-producer error, and the requirement that a flushed slot stays dark after its register completes. Randomised traffic against a bench-side model mixes all of these with overlapping flushes and slot rewrites.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

    localparam int NUM_SRC = 2;

    typedef enum logic {
        SRC_AVAIL = 1'b0,
        SRC_WAIT  = 1'b1
    } src_state_e;

    function automatic logic reg_tracked(input logic [31:0] idx, input int limit);
        return idx < 32'(limit);
    endfunction

endpackage

// File: rtl/sbw_regbits.sv
module sbw_regbits #(
    parameter int NUM_PREGS = 32,
    parameter int REG_W     = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 set_valid,
    input  logic [REG_W-1:0]     set_reg,
    input  logic                 clr_valid,
    input  logic [REG_W-1:0]     clr_reg,
    output logic [NUM_PREGS-1:0] bits
);
    // Numbers at or above NUM_PREGS match no bit, so they are ignored here.
    for (genvar i = 0; i < NUM_PREGS; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                bits[i] <= 1'b0;
            end else if (clr_valid && clr_reg == REG_W'(i)) begin
                bits[i] <= 1'b0;
            end else if (set_valid && set_reg == REG_W'(i)) begin
                bits[i] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sbw_src_check.sv
module sbw_src_check
    import sbw_pkg::*;
#(
    parameter int NUM_PREGS = 32,
    parameter int REG_W     = 6
) (
    input  logic [REG_W-1:0]     src_reg,
    input  logic                 rename_rdy,
    input  logic [NUM_PREGS-1:0] sb_bits,
    input  logic                 byp_valid,
    input  logic [REG_W-1:0]     byp_reg,
    output src_state_e           state,
    output logic                 ready
);
    logic tracked;
    logic sb_hit;
    logic byp_hit;

    always_comb begin
        tracked = reg_tracked(32'(src_reg), NUM_PREGS);
        sb_hit  = 1'b0;
        for (int i = 0; i < NUM_PREGS; i++) begin
            if (src_reg == REG_W'(i) && sb_bits[i]) sb_hit = 1'b1;
        end
        byp_hit = tracked && byp_valid && (byp_reg == src_reg);
        ready   = rename_rdy || !tracked || sb_hit || byp_hit;
        state   = ready ? SRC_AVAIL : SRC_WAIT;
    end
endmodule

// File: rtl/sbw_slot.sv
module sbw_slot
    import sbw_pkg::*;
#(
    parameter int REG_W = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  src_state_e [NUM_SRC-1:0] load_state,
    input  logic [NUM_SRC*REG_W-1:0] load_tag,
    input  logic                     flush,
    input  logic                     wake_valid,
    input  logic [REG_W-1:0]         wake_reg,
    input  logic [REG_W-1:0]         query_reg,
    output logic                     ready,
    output logic                     waits_on_query
);
    logic                     valid_q;
    logic [NUM_SRC-1:0]       wait_q;
    logic [NUM_SRC*REG_W-1:0] tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            wait_q  <= '0;
            tag_q   <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            tag_q   <= load_tag;
            for (int s = 0; s < NUM_SRC; s++) wait_q[s] <= (load_state[s] == SRC_WAIT);
        end else if (flush) begin
            valid_q <= 1'b0;
            wait_q  <= '0;
        end else begin
            for (int s = 0; s < NUM_SRC; s++) begin
                if (valid_q && wait_q[s] && wake_valid &&
                    tag_q[s*REG_W +: REG_W] == wake_reg) begin
                    wait_q[s] <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        ready          = valid_q && (wait_q == '0);
        waits_on_query = 1'b0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (valid_q && wait_q[s] && tag_q[s*REG_W +: REG_W] == query_reg)
                waits_on_query = 1'b1;
        end
    end
endmodule

// File: rtl/wakeup_scoreboard.sv
module wakeup_scoreboard
    import sbw_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int NUM_PREGS   = 32,
    localparam int REG_W      = $clog2(NUM_PREGS) + 1,
    localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ins_valid,
    input  logic [IDX_W-1:0]         ins_slot,
    input  logic [NUM_SRC*REG_W-1:0] ins_src_reg,
    input  logic [NUM_SRC-1:0]       ins_src_rdy,
    input  logic [REG_W-1:0]         ins_dst_reg,
    input  logic                     cmp_valid,
    input  logic [REG_W-1:0]         cmp_reg,
    input  logic [NUM_ENTRIES-1:0]   flush_mask,
    output logic [NUM_SRC-1:0]       ins_src_ready,
    output logic                     prod_err,
    output logic [NUM_ENTRIES-1:0]   entry_ready,
    output logic [NUM_PREGS-1:0]     reg_ready
);
    src_state_e [NUM_SRC-1:0] src_state;
    logic [NUM_ENTRIES-1:0]   load_vec;
    logic [NUM_ENTRIES-1:0]   holds_dst;
    logic                     dst_tracked;

    sbw_regbits #(.NUM_PREGS(NUM_PREGS), .REG_W(REG_W)) u_bits (
        .clk       (clk),
        .rst       (rst),
        .set_valid (cmp_valid),
        .set_reg   (cmp_reg),
        .clr_valid (ins_valid),
        .clr_reg   (ins_dst_reg),
        .bits      (reg_ready)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        sbw_src_check #(.NUM_PREGS(NUM_PREGS), .REG_W(REG_W)) u_chk (
            .src_reg    (ins_src_reg[s*REG_W +: REG_W]),
            .rename_rdy (ins_src_rdy[s]),
            .sb_bits    (reg_ready),
            .byp_valid  (cmp_valid),
            .byp_reg    (cmp_reg),
            .state      (src_state[s]),
            .ready      (ins_src_ready[s])
        );
    end

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_slot
        assign load_vec[e] = ins_valid && (ins_slot == IDX_W'(e));
        sbw_slot #(.REG_W(REG_W)) u_slot (
            .clk            (clk),
            .rst            (rst),
            .load           (load_vec[e]),
            .load_state     (src_state),
            .load_tag       (ins_src_reg),
            .flush          (flush_mask[e]),
            .wake_valid     (cmp_valid),
            .wake_reg       (cmp_reg),
            .query_reg      (ins_dst_reg),
            .ready          (entry_ready[e]),
            .waits_on_query (holds_dst[e])
        );
    end

    always_comb begin
        dst_tracked = reg_tracked(32'(ins_dst_reg), NUM_PREGS);
        prod_err    = ins_valid && dst_tracked &&
                      ((holds_dst & ~load_vec) != '0) &&
                      !(cmp_valid && cmp_reg == ins_dst_reg);
    end
endmodule

// File: rtl/sbw_checker.sv
module sbw_checker
    import sbw_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int NUM_PREGS   = 32,
    parameter int REG_W       = 6,
    parameter int IDX_W       = 3
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     ins_valid,
    input logic [IDX_W-1:0]         ins_slot,
    input logic [NUM_SRC*REG_W-1:0] ins_src_reg,
    input logic [NUM_SRC-1:0]       ins_src_rdy,
    input logic [REG_W-1:0]         ins_dst_reg,
    input logic                     cmp_valid,
    input logic [REG_W-1:0]         cmp_reg,
    input logic [NUM_ENTRIES-1:0]   flush_mask,
    input logic [NUM_SRC-1:0]       ins_src_ready,
    input logic                     prod_err,
    input logic [NUM_ENTRIES-1:0]   entry_ready,
    input logic [NUM_PREGS-1:0]     reg_ready
);
    logic set_pend_q, clr_pend_q;
    int   set_idx_q, clr_idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            set_pend_q <= 1'b0;
            clr_pend_q <= 1'b0;
            set_idx_q  <= 0;
            clr_idx_q  <= 0;
        end else begin
            set_pend_q <= cmp_valid && reg_tracked(32'(cmp_reg), NUM_PREGS) &&
                          !(ins_valid && ins_dst_reg == cmp_reg);
            set_idx_q  <= int'(cmp_reg);
            clr_pend_q <= ins_valid && reg_tracked(32'(ins_dst_reg), NUM_PREGS);
            clr_idx_q  <= int'(ins_dst_reg);
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (reg_ready == '0 && entry_ready == '0));

    a_r4_dst_cleared: assert property (@(posedge clk) disable iff (rst)
        clr_pend_q |-> !reg_ready[clr_idx_q]);

    a_r5_cmp_sets: assert property (@(posedge clk) disable iff (rst)
        set_pend_q |-> reg_ready[set_idx_q]);

    a_r10_bits_hold: assert property (@(posedge clk) disable iff (rst)
        (!ins_valid && !cmp_valid) |=> $stable(reg_ready));

    a_r8_err_needs_insert: assert property (@(posedge clk) disable iff (rst)
        prod_err |-> ins_valid);

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src_a
        a_r2_rename_flag: assert property (@(posedge clk) disable iff (rst)
            (ins_valid && ins_src_rdy[s]) |-> ins_src_ready[s]);
        a_r7_oor_source: assert property (@(posedge clk) disable iff (rst)
            (ins_valid && !reg_tracked(32'(ins_src_reg[s*REG_W +: REG_W]), NUM_PREGS))
            |-> ins_src_ready[s]);
    end

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_slot_a
        a_r9_flush_drops: assert property (@(posedge clk) disable iff (rst)
            (flush_mask[e] && !(ins_valid && ins_slot == IDX_W'(e))) |=> !entry_ready[e]);
    end
endmodule

bind wakeup_scoreboard sbw_checker #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .NUM_PREGS   (NUM_PREGS),
    .REG_W       (REG_W),
    .IDX_W       (IDX_W)
) u_sbw_checker (
    .clk           (clk),
    .rst           (rst),
    .ins_valid     (ins_valid),
    .ins_slot      (ins_slot),
    .ins_src_reg   (ins_src_reg),
    .ins_src_rdy   (ins_src_rdy),
    .ins_dst_reg   (ins_dst_reg),
    .cmp_valid     (cmp_valid),
    .cmp_reg       (cmp_reg),
    .flush_mask    (flush_mask),
    .ins_src_ready (ins_src_ready),
    .prod_err      (prod_err),
    .entry_ready   (entry_ready),
    .reg_ready     (reg_ready)
);

// File: tb/wakeup_scoreboard_bench.sv
module wakeup_scoreboard_bench;
    localparam int NE    = 8;
    localparam int NP    = 32;
    localparam int REG_W = $clog2(NP) + 1;
    localparam int IDX_W = $clog2(NE);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ins_valid = 1'b0;
    logic [IDX_W-1:0] ins_slot = '0;
    logic [2*REG_W-1:0] ins_src_reg = '0;
    logic [1:0]       ins_src_rdy = '0;
    logic [REG_W-1:0] ins_dst_reg = '0;
    logic             cmp_valid = 1'b0;
    logic [REG_W-1:0] cmp_reg = '0;
    logic [NE-1:0]    flush_mask = '0;
    logic [1:0]       ins_src_ready;
    logic             prod_err;
    logic [NE-1:0]    entry_ready;
    logic [NP-1:0]    reg_ready;

    always #2 clk = ~clk;

    wakeup_scoreboard #(.NUM_ENTRIES(NE), .NUM_PREGS(NP)) u_wakeup_scoreboard (
        .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_slot(ins_slot),
        .ins_src_reg(ins_src_reg), .ins_src_rdy(ins_src_rdy), .ins_dst_reg(ins_dst_reg),
        .cmp_valid(cmp_valid), .cmp_reg(cmp_reg), .flush_mask(flush_mask),
        .ins_src_ready(ins_src_ready), .prod_err(prod_err),
        .entry_ready(entry_ready), .reg_ready(reg_ready)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // bench model state
    bit m_sb  [NP];
    bit m_val [NE];
    bit m_wait[NE][2];
    int m_tag [NE][2];

    // stimulus held as integers
    bit iv; int islot; int isrc[2]; bit irdy[2]; int idst;
    bit cv; int creg; bit [NE-1:0] fmask;

    function automatic bit exp_src_ready(int s);
        int r = isrc[s];
        if (irdy[s] || r >= NP) return 1;
        if (m_sb[r]) return 1;
        if (cv && creg == r) return 1;
        return 0;
    endfunction

    function automatic bit exp_err();
        if (!iv || idst >= NP) return 0;
        if (cv && creg == idst) return 0;
        for (int e = 0; e < NE; e++) begin
            if (e != islot && m_val[e])
                for (int s = 0; s < 2; s++)
                    if (m_wait[e][s] && m_tag[e][s] == idst) return 1;
        end
        return 0;
    endfunction

    function automatic logic [NE-1:0] exp_entry_ready();
        logic [NE-1:0] v;
        for (int e = 0; e < NE; e++) v[e] = m_val[e] && !m_wait[e][0] && !m_wait[e][1];
        return v;
    endfunction

    function automatic logic [NP-1:0] exp_reg_ready();
        logic [NP-1:0] v;
        for (int i = 0; i < NP; i++) v[i] = m_sb[i];
        return v;
    endfunction

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic set_idle();
        iv = 0; islot = 0; isrc[0] = 0; isrc[1] = 0; irdy[0] = 0; irdy[1] = 0;
        idst = 63; cv = 0; creg = 0; fmask = '0;
    endtask

    // one cycle: drive at negedge, check same-cycle outputs, update model at posedge, check state
    task automatic cyc(string tag);
        bit nr[2];
        ins_valid   = iv;
        ins_slot    = IDX_W'(islot);
        ins_src_reg = {REG_W'(isrc[1]), REG_W'(isrc[0])};
        ins_src_rdy = {irdy[1], irdy[0]};
        ins_dst_reg = REG_W'(idst);
        cmp_valid   = cv;
        cmp_reg     = REG_W'(creg);
        flush_mask  = fmask;
        #1;
        if (iv) check(tag, "ins_src_ready", 64'(ins_src_ready),
                      64'({exp_src_ready(1), exp_src_ready(0)}));
        check(tag, "prod_err", 64'(prod_err), 64'(exp_err()));
        nr[0] = exp_src_ready(0); nr[1] = exp_src_ready(1);
        @(posedge clk);
        for (int e = 0; e < NE; e++) begin
            if (fmask[e]) begin m_val[e] = 0; m_wait[e][0] = 0; m_wait[e][1] = 0; end
            else if (cv && creg < NP && m_val[e])
                for (int s = 0; s < 2; s++)
                    if (m_wait[e][s] && m_tag[e][s] == creg) m_wait[e][s] = 0;
        end
        if (cv && creg < NP) m_sb[creg] = 1;
        if (iv) begin
            m_val[islot] = 1;
            for (int s = 0; s < 2; s++) begin
                m_wait[islot][s] = !nr[s];
                m_tag[islot][s]  = isrc[s];
            end
            if (idst < NP) m_sb[idst] = 0;
        end
        #1;
        check(tag, "entry_ready", 64'(entry_ready), 64'(exp_entry_ready()));
        check(tag, "reg_ready", 64'(reg_ready), 64'(exp_reg_ready()));
        @(negedge clk);
        set_idle();
    endtask

    task automatic ins(int slot, int s0, bit r0, int s1, bit r1, int dst);
        iv = 1; islot = slot; isrc[0] = s0; irdy[0] = r0; isrc[1] = s1; irdy[1] = r1; idst = dst;
    endtask

    initial begin
        set_idle();
        for (int i = 0; i < NP; i++) m_sb[i] = 0;
        for (int e = 0; e < NE; e++) begin
            m_val[e] = 0; m_wait[e][0] = 0; m_wait[e][1] = 0; m_tag[e][0] = 0; m_tag[e][1] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "reg_ready in reset", 64'(reg_ready), 64'(0));
        rst = 1'b0;
        #1;
        check("R1", "entry_ready after reset", 64'(entry_ready), 64'(0));
        @(negedge clk);

        // R3: waits on 5, R2: rename flag on src1
        ins(0, 5, 0, 6, 1, 10);           cyc("R3");
        check("R3", "slot0 still waiting", 64'(entry_ready[0]), 64'(0));
        cv = 1; creg = 5;                 cyc("R5");
        check("R3", "slot0 woken", 64'(entry_ready[0]), 64'(1));
        // R2: scoreboard already set for 5
        ins(1, 5, 0, 40, 0, 63);          cyc("R2");
        check("R2", "slot1 ready from scoreboard", 64'(entry_ready[1]), 64'(1));
        // R5: two slots wait on 7
        ins(2, 7, 0, 6, 1, 63);           cyc("R5");
        ins(3, 9, 1, 7, 0, 63);           cyc("R5");
        check("R5", "slots 2,3 waiting", 64'(entry_ready[3:2]), 64'(0));
        cv = 1; creg = 7;                 cyc("R5");
        check("R5", "slots 2,3 woken together", 64'(entry_ready[3:2]), 64'(3));
        // R6: same-cycle bypass
        ins(4, 8, 0, 6, 1, 63); cv = 1; creg = 8; cyc("R6");
        check("R6", "bypassed slot4 ready", 64'(entry_ready[4]), 64'(1));
        // R7: out-of-range regs
        ins(5, 40, 0, 33, 0, 50);         cyc("R7");
        check("R7", "slot5 ready with untracked sources", 64'(entry_ready[5]), 64'(1));
        cv = 1; creg = 45;                cyc("R7");
        // R4: destination clears a set bit
        ins(5, 6, 1, 6, 1, 5);            cyc("R4");
        check("R4", "reg5 cleared", 64'(reg_ready[5]), 64'(0));
        // R8: duplicate producer
        ins(6, 12, 0, 6, 1, 63);          cyc("R8");
        ins(7, 6, 1, 6, 1, 12);           cyc("R8");
        ins(7, 6, 1, 6, 1, 12); cv = 1; creg = 13; cyc("R8");
        // R9: flush, then broadcast must not revive
        ins(6, 12, 0, 6, 1, 63);          cyc("R9");
        fmask = 8'h40;                    cyc("R9");
        cv = 1; creg = 12;                cyc("R9");
        check("R9", "flushed slot6 stays low", 64'(entry_ready[6]), 64'(0));
        // R10: idle cycles hold the scoreboard
        cyc("R10"); cyc("R10");

        // random traffic
        void'($urandom(32'd4242));
        for (int n = 0; n < 3000; n++) begin
            iv = ($urandom % 3) != 0;
            islot = $urandom % NE;
            for (int s = 0; s < 2; s++) begin
                isrc[s] = $urandom % 40;
                irdy[s] = ($urandom % 4) == 0;
            end
            idst  = $urandom % 40;
            cv    = ($urandom % 2) != 0;
            creg  = $urandom % 40;
            fmask = (($urandom % 8) == 0) ? NE'($urandom) : '0;
            cyc("R10");
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule